// File: doc/BRIEF.md
# Idle and Slow-Idle Clock Controller

This block carries out the processor's wait-for-interrupt command. When the core issues an idle command, the block holds instruction execution until the interrupt controller reports a serviceable interrupt. It then releases the core with a one-cycle resume pulse, and the core carries on at the instruction that follows the idle. The interrupt is serviced first. A slow variant of the same command also lowers the core's effective rate. During slow idle the core logic stays fully working, but it only advances on a clock-enable pulse that appears once every 16, 32, 64 or 128 input cycles. The instruction selects which of these divisors applies.

Cycle-steal requests from host DMA, block DMA and serial autobuffering are served in every state, including both idle forms. They form a valid/ready stream. Ready always follows valid in the same cycle, so the block never applies back-pressure. In normal running, an accepted steal takes that one cycle away from the core, and the stall output is raised for it. During idle, steals are accepted without touching the idle state or the divider phase. The interrupt-pending input comes from outside this block and is assumed to be already masked. Arbitration between interrupts and the DMA engines themselves belong to other blocks.

Top module: `idle_clk_ctrl`

## Requirements
- R1: After reset, core_ce is 1, stall is 0, resume is 0, and the block is running (not idle).
- R2: An idle_cmd sampled with slow_sel=0 while running raises stall from the next cycle on. core_ce stays 1 every cycle during this plain idle.
- R3: Plain idle lasts with no time limit. At the first clock edge where irq_pending is 1, the block leaves idle: in the next cycle stall falls (unless a steal is present) and resume is 1 for exactly that one cycle.
- R4: An idle_cmd sampled with slow_sel=1 enters slow idle with divisor n = 16 << div_code, where div_code 00=16, 01=32, 10=64 and 11=128. Counting the first slow-idle cycle as 1, core_ce is 1 in cycle n, 2n, 3n and so on, and 0 in every other slow-idle cycle.
- R5: Slow idle ends only at an edge where core_ce is 1 and irq_pending is 1. In the next cycle core_ce is 1, resume is 1 for that one cycle, and the block is running again at full rate with the divider phase cleared.
- R6: In slow idle, irq_pending that is high only in cycles where core_ce is 0 does not end idle.
- R7: steal_ready equals steal_valid in the same cycle in every state. While running, an accepted steal raises stall for that cycle only. Steals have no effect on the idle state, the divider phase or resume.
- R8: An idle_cmd that arrives while already idle is ignored. irq_pending while running never produces resume.
- R9: The divisor and the idle form are captured when idle is entered. Changes on slow_sel or div_code during idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_cmd | input | 1 | One-cycle idle command from the core |
| slow_sel | input | 1 | 1 selects slow idle for this command |
| div_code | input | 2 | Slow-idle divisor code (00=16, 01=32, 10=64, 11=128) |
| irq_pending | input | 1 | An unmasked interrupt is pending |
| steal_valid | input | 1 | DMA or autobuffer cycle-steal request |
| steal_ready | output | 1 | Cycle steal accepted in this cycle |
| core_ce | output | 1 | Core clock enable (divided during slow idle) |
| stall | output | 1 | Execution held (idle, or a steal while running) |
| resume | output | 1 | One-cycle pulse: continue after the idle |

## Verification
The bench goes after wakes in slow idle where the interrupt rises between divided edges. A design that sampled irq_pending on every input cycle would resume early and break the divided-rate wake timing. It also checks the first pulse after entry for each divisor code. An off-by-one counter would shift every pulse by a cycle, and a wrong shift would pick the wrong rate. Idle commands and divisor changes that arrive during idle are also driven. A block that re-latched them would restart or re-scale the divider. Steals are mixed into every state, so a design that blocked them in idle, or let them disturb the divider phase, shows up as a stall, ready or core_ce mismatch.

// File: rtl/idle_ctl_pkg.sv
package idle_ctl_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_SLOW = 2'd2
  } idle_mode_e;

  // Divide ratio for a divisor code: base shifted left by the code.
  function automatic int unsigned div_ratio(input int unsigned base, input int unsigned code);
    return base << code;
  endfunction

endpackage

// File: rtl/idle_div_counter.sv
module idle_div_counter
  import idle_ctl_pkg::*;
#(
  parameter int unsigned BASE_DIV = 16,
  parameter int unsigned CODE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int unsigned MAX_DIV = BASE_DIV << ((1 << CODE_W) - 1);
  localparam int unsigned CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = CNT_W'(div_ratio(BASE_DIV, 32'(code)) - 1);
  end

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Divided pulses are isolated: never two in a row (R4).
  assert_tick_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> !tick);

  // Counter never passes the selected limit (R4).
  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));

  // Counter starts from zero on each entry (R4).
  assert_cnt_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/idle_mode_fsm.sv
module idle_mode_fsm
  import idle_ctl_pkg::*;
#(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_cmd,
  input  logic              slow_sel,
  input  logic [CODE_W-1:0] code_in,
  input  logic              irq_pending,
  input  logic              div_tick,
  output idle_mode_e        mode,
  output logic [CODE_W-1:0] code_q,
  output logic              resume,
  output logic              in_idle
);
  idle_mode_e        mode_q, mode_d;
  logic [CODE_W-1:0] code_d;
  logic              resume_d;

  always_comb begin
    mode_d   = mode_q;
    code_d   = code_q;
    resume_d = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        if (idle_cmd) begin
          mode_d = slow_sel ? MODE_SLOW : MODE_WAIT;
          code_d = code_in;
        end
      end
      MODE_WAIT: begin
        if (irq_pending) begin
          mode_d   = MODE_RUN;
          resume_d = 1'b1;
        end
      end
      MODE_SLOW: begin
        if (div_tick && irq_pending) begin
          mode_d   = MODE_RUN;
          resume_d = 1'b1;
        end
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      code_q <= '0;
      resume <= 1'b0;
    end else begin
      mode_q <= mode_d;
      code_q <= code_d;
      resume <= resume_d;
    end
  end

  assign mode    = mode_q;
  assign in_idle = (mode_q != MODE_RUN);

  // Resume lasts a single cycle (R3).
  assert_resume_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  // Plain idle ends on the edge after a pending interrupt (R3).
  assert_wait_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_WAIT && irq_pending) |=> (resume && mode_q == MODE_RUN));

  // Slow idle holds between divided edges (R6).
  assert_slow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLOW && !div_tick) |=> (mode_q == MODE_SLOW));

  // Captured divisor is stable while idle (R9).
  assert_code_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_RUN) |=> $stable(code_q));

  // Running never yields a resume on the next cycle (R8).
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN) |=> !resume);

endmodule

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl
  import idle_ctl_pkg::*;
#(
  parameter int unsigned BASE_DIV = 16,
  parameter int unsigned CODE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_cmd,
  input  logic              slow_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic              irq_pending,
  input  logic              steal_valid,
  output logic              steal_ready,
  output logic              core_ce,
  output logic              stall,
  output logic              resume
);
  idle_mode_e        mode;
  logic [CODE_W-1:0] code_q;
  logic              in_idle;
  logic              div_tick;
  logic              slow_run;

  assign slow_run = (mode == MODE_SLOW);

  idle_mode_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_cmd    (idle_cmd),
    .slow_sel    (slow_sel),
    .code_in     (div_code),
    .irq_pending (irq_pending),
    .div_tick    (div_tick),
    .mode        (mode),
    .code_q      (code_q),
    .resume      (resume),
    .in_idle     (in_idle)
  );

  idle_div_counter #(.BASE_DIV(BASE_DIV), .CODE_W(CODE_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (slow_run),
    .code  (code_q),
    .tick  (div_tick)
  );

  // Cycle steals are always accepted; no back-pressure.
  assign steal_ready = steal_valid;
  assign core_ce     = !slow_run || div_tick;
  assign stall       = in_idle || steal_valid;

  // Slow-idle wake returns full rate at once (R5).
  assert_wake_full_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_run && div_tick && irq_pending) |=> (core_ce && resume && !in_idle));

  // Resume only follows an idle cycle (R3).
  assert_resume_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> $past(in_idle));

endmodule

// File: tb/test_idle_clk_ctrl.sv
module test_idle_clk_ctrl;
  localparam int BASE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle_cmd = 1'b0, slow_sel = 1'b0, irq_pending = 1'b0, steal_valid = 1'b0;
  logic [1:0] div_code = 2'd0;
  logic       steal_ready, core_ce, stall, resume;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  idle_clk_ctrl i_idle_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .idle_cmd(idle_cmd), .slow_sel(slow_sel),
    .div_code(div_code), .irq_pending(irq_pending), .steal_valid(steal_valid),
    .steal_ready(steal_ready), .core_ce(core_ce), .stall(stall), .resume(resume)
  );

  // Reference model: 0 run, 1 plain idle, 2 slow idle.
  int m_mode = 0, m_cnt = 0, m_n = BASE;
  bit m_res = 0;

  function automatic int ratio(input logic [1:0] c);
    return BASE << c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_n = BASE; m_res = 0;
    end else begin
      case (m_mode)
        0: begin
          m_res = 0;
          if (idle_cmd) begin
            m_mode = slow_sel ? 2 : 1; m_n = ratio(div_code); m_cnt = 0;
          end
        end
        1: begin
          m_res = irq_pending;
          if (irq_pending) m_mode = 0;
        end
        default: begin
          m_res = 0;
          if (m_cnt == m_n - 1) begin
            m_cnt = 0;
            if (irq_pending) begin m_mode = 0; m_res = 1; end
          end else m_cnt++;
        end
      endcase
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(core_ce, (m_mode != 2) || (m_cnt == m_n - 1), (m_mode == 2) ? "R4 core_ce" : "R2 core_ce");
      chk(stall, (m_mode != 0) || steal_valid, (m_mode == 0 && steal_valid) ? "R7 stall" : "R2 stall");
      chk(resume, m_res, "R3/R5 resume");
      chk(steal_ready, steal_valid, "R7 steal_ready");
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic drive_idle(input bit slow, input logic [1:0] code);
    @(negedge clk);
    idle_cmd = 1; slow_sel = slow; div_code = code;
    @(negedge clk);
    idle_cmd = 0;
  endtask

  initial begin
    void'($urandom(32'h1D1E_5EED));
    repeat (3) @(negedge clk);
    #3;
    chk(core_ce, 1'b1, "R1 core_ce");
    chk(stall, 1'b0, "R1 stall");
    chk(resume, 1'b0, "R1 resume");
    @(negedge clk);
    rst_n = 1;

    // R8: interrupt while running gives no resume.
    irq_pending = 1; cyc(3); #3; chk(resume, 1'b0, "R8 irq while running"); irq_pending = 0;

    // R2, R3: plain idle held long, steals inside, then wake.
    drive_idle(0, 2'd3);
    steal_valid = 1; cyc(60); steal_valid = 0;
    #3; chk(stall, 1'b1, "R3 long plain idle");
    irq_pending = 1; cyc(1); irq_pending = 0; #3;
    chk(resume, 1'b1, "R3 resume pulse");
    cyc(1); #3; chk(resume, 1'b0, "R3 pulse ends");

    // R4: first pulse position for every code.
    for (int c = 0; c < 4; c++) begin
      int seen;
      @(negedge clk); idle_cmd = 1; slow_sel = 1; div_code = 2'(c);
      @(negedge clk); idle_cmd = 0; #3;
      seen = 1;
      while (!core_ce && seen < 300) begin @(negedge clk); #3; seen++; end
      chk(seen == ratio(2'(c)), 1'b1, "R4 first pulse position");
      // R9, R8: change inputs mid-idle; pulse spacing must stay.
      div_code = 2'(3 - c); slow_sel = 0; idle_cmd = 1; @(negedge clk); idle_cmd = 0;
      // R6: irq between pulses.
      irq_pending = 1; cyc(2); irq_pending = 0; #3;
      chk(stall, 1'b1, "R6 no wake between pulses");
      seen = 3;
      while (!core_ce && seen < 300) begin @(negedge clk); #3; seen++; end
      chk(seen == ratio(2'(c)), 1'b1, "R9 spacing kept");
      // R5: wake on a divided edge.
      irq_pending = 1;
      while (!resume) @(negedge clk);
      irq_pending = 0; #3;
      chk(core_ce, 1'b1, "R5 full rate after wake");
    end

    // Random phase.
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      idle_cmd = ($urandom % 40) == 0;
      if ($urandom % 4 == 0) slow_sel = $urandom % 2;
      if ($urandom % 4 == 0) div_code = 2'($urandom % 4);
      if (!irq_pending && ($urandom % 150) == 0) irq_pending = 1;
      else if (irq_pending && ($urandom % 8) == 0) irq_pending = 0;
      steal_valid = ($urandom % 4) == 0;
    end
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule